// File: doc/BRIEF.md
# Ethernet Transmit Queue Manager

This block owns a shared transmit packet memory that sits between a host register interface and a frame transmitter. For each frame, the host writes one header register. That register carries a 16-bit control word and an 11-bit byte count. The host then pushes the frame body as 32-bit words through a data port. The port's write pointer can advance by itself after each access, or it can hold its position.

A frame becomes eligible for transmission in one of two ways:
- **Automatic mode:** the frame is queued as soon as its last data word has been written.
- **Manual mode:** the host sets a self-clearing enqueue bit. That bit reads back as one until the frame has been fully drained.

The block keeps an exact count of free memory in bytes. Each frame costs its byte count plus a 4-byte header, rounded up to a whole word. A frame that does not fit is refused, and a sticky error flag is raised.

The host can post a space request, given in 32-bit words, and arm a check against it. The block then raises a space-available status bit once enough memory is free. A transmit-done status bit is raised each time a frame leaves the memory. Both status bits can be enabled onto an interrupt line.

The transmitter side is a valid/ready drain port. It delivers the stored header word first and then the payload words, unchanged and in the order the frames were queued.

Top module: `txq_mgr`

## Requirements
- R1: After reset, the free-space register (address 1) reads MEM_BYTES. The status register (address 4) and the control register (address 0) read 0, `irq` is 0 and `tx_valid` is 0.
- R2: A header write (address 5) is refused under any of three conditions: its byte count (bits 10:0) is 0, its footprint exceeds the free space, or a previous frame is still open. On refusal, status bit 0 is set and stays set until cleared. Free space and the queue are unchanged.
- R3: An accepted header reduces free space by 4*(1+ceil(bytecount/4)) bytes. The same amount is returned when the frame's last word is drained. Free space reaches 0 exactly when the memory is full.
- R4: With control bit 2 (auto mode) and bit 3 (auto-increment) set, a frame is queued when its last payload word is written, and not before.
- R5: With auto mode clear, writing control bit 0 queues the open frame. Bit 0 then reads 1 until that frame has finished draining, and 0 afterwards. A frame that is not enqueued is never offered to the drain port.
- R6: With control bit 3 clear, the data-port pointer does not move, so successive data writes overwrite the same payload word.
- R7: Writing control bit 1 arms a space check against the word count in address 2. Once free bytes are at least 4 times that count, status bit 6 is set and bit 1 reads 0 again. While the condition is not met, the check stays armed.
- R8: Status bit 14 is set in the cycle after the last word of a frame is accepted on the drain port.
- R9: Status bits are cleared by writing 1 to them. `irq` is high while status bit 14 or bit 6 is set together with the same bit of the enable register (address 3).
- R10: The drain port delivers the header word as {control word, 5'b0, byte count}, with `tx_first` high. Reserved header bits 15:11 are dropped. Payload words follow unchanged, and `tx_last` is high on the final one.
- R11: Frames leave in the order they were queued, including when their storage wraps past the end of the memory.
- R12: A data-port write (address 6) while no frame is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| tx_valid | output | 1 | Drain port has a word |
| tx_ready | input | 1 | Transmitter accepts the word |
| tx_data | output | 32 | Header or payload word |
| tx_first | output | 1 | Current word is a frame header |
| tx_last | output | 1 | Current word ends the frame |

## Verification
The bench builds the block with MEM_BYTES set to 64, which gives a 16-word memory. At that size, repeated two-frame rounds carry the write and drain pointers around the end of the memory several times. A single frame of byte count 60 fills the memory exactly, so free space drops to zero and the read pointer catches up with the write pointer on a non-empty queue. A byte count of 100 and any header written while the memory is full exercise the footprint refusal. Because the memory is small, the space-request threshold can be crossed by draining a single frame.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int TXQ_BC_W = 11;                 // byte-count field width
  localparam int TXQ_PW_W = TXQ_BC_W - 1;        // payload word count width

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_FREE  = 3'd1;
  localparam logic [2:0] REG_SREQ  = 3'd2;
  localparam logic [2:0] REG_IEN   = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;
  localparam logic [2:0] REG_FHDR  = 3'd5;
  localparam logic [2:0] REG_DATA  = 3'd6;

  localparam int ST_ERR   = 0;
  localparam int ST_SPACE = 6;
  localparam int ST_DONE  = 14;

  localparam logic [15:0] IEN_MASK  = 16'h4040;
  localparam logic [15:0] STAT_MASK = 16'h4041;

  typedef struct packed {
    logic [15:0]         ctl;
    logic [4:0]          rsv;
    logic [TXQ_BC_W-1:0] bc;
  } txq_hdr_t;

  // payload words needed for a byte count: ceil(bc/4)
  function automatic logic [TXQ_PW_W-1:0] fn_payload_words(input logic [TXQ_BC_W-1:0] bc);
    logic [TXQ_BC_W:0] t;
    t = {1'b0, bc} + (TXQ_BC_W+1)'(3);
    return t[TXQ_BC_W:2];
  endfunction

  // total words a frame occupies, header word included
  function automatic logic [TXQ_PW_W:0] fn_foot_words(input logic [TXQ_BC_W-1:0] bc);
    return {1'b0, fn_payload_words(bc)} + (TXQ_PW_W+1)'(1);
  endfunction

  // pointer advance modulo the memory depth; n never exceeds depth
  function automatic int unsigned fn_wrap_add(input int unsigned ptr, input int unsigned n,
                                              input int unsigned depth);
    int unsigned s;
    s = ptr + n;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // space request is in 32-bit words, free space is in bytes
  function automatic logic fn_space_met(input int unsigned free_b, input logic [15:0] req_w);
    return free_b >= {14'd0, req_w, 2'b00};
  endfunction

endpackage

// File: rtl/txq_space.sv
module txq_space
  import txq_pkg::*;
#(
  parameter int DEPTH = 1536,
  parameter int FW_W  = $clog2(DEPTH + 1),
  parameter int FB_W  = FW_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [FW_W-1:0] take_words,
  input  logic            give,
  input  logic [FW_W-1:0] give_words,
  input  logic            arm_set,
  input  logic [15:0]     req_words,
  output logic [FW_W-1:0] free_words,
  output logic [FB_W-1:0] free_bytes,
  output logic            armed,
  output logic            space_hit
);

  logic [FW_W-1:0] sub_w, add_w;

  assign sub_w      = take ? take_words : '0;
  assign add_w      = give ? give_words : '0;
  assign free_bytes = {free_words, 2'b00};
  assign space_hit  = armed && fn_space_met(32'(free_bytes), req_words);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_words <= FW_W'(DEPTH);
      armed      <= 1'b0;
    end else begin
      free_words <= free_words - sub_w + add_w;
      if (arm_set)        armed <= 1'b1;
      else if (space_hit) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DEPTH = 1536,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_wr,
  input  txq_hdr_t      hdr_in,
  input  logic          fits,
  input  logic          data_wr,
  input  logic [31:0]   data_in,
  input  logic          autoinc,
  input  logic          auto_mode,
  input  logic          enq_wr,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          hdr_accept,
  output logic          hdr_reject,
  output logic          commit,
  output logic          open,
  output logic [AW-1:0] frame_end
);

  logic [31:0]         mem [DEPTH];
  logic [AW-1:0]       nxt_base, wptr;
  logic [TXQ_PW_W-1:0] left;
  logic                data_take, last_word;
  logic                mem_we;
  logic [AW-1:0]       mem_wa;
  logic [31:0]         mem_wd;
  txq_hdr_t            hdr_clean;

  assign hdr_accept = hdr_wr && !open && (hdr_in.bc != '0) && fits;
  assign hdr_reject = hdr_wr && !hdr_accept;
  assign data_take  = data_wr && open && (left != '0);
  assign last_word  = data_take && autoinc && (left == TXQ_PW_W'(1));
  assign commit     = open && (enq_wr || (auto_mode && last_word));

  always_comb begin
    hdr_clean     = hdr_in;
    hdr_clean.rsv = '0;
  end

  assign mem_we = hdr_accept || data_take;
  assign mem_wa = hdr_accept ? nxt_base : wptr;
  assign mem_wd = hdr_accept ? 32'(hdr_clean) : data_in;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_base  <= '0;
      wptr      <= '0;
      left      <= '0;
      open      <= 1'b0;
      frame_end <= '0;
    end else begin
      if (hdr_accept) begin
        open      <= 1'b1;
        wptr      <= AW'(fn_wrap_add(32'(nxt_base), 1, DEPTH));
        left      <= fn_payload_words(hdr_in.bc);
        frame_end <= AW'(fn_wrap_add(32'(nxt_base), 32'(fn_foot_words(hdr_in.bc)), DEPTH));
      end else begin
        if (data_take && autoinc) begin
          wptr <= AW'(fn_wrap_add(32'(wptr), 1, DEPTH));
          left <= left - TXQ_PW_W'(1);
        end
        if (commit) begin
          open     <= 1'b0;
          nxt_base <= frame_end;
        end
      end
    end
  end

endmodule

// File: rtl/txq_drain.sv
module txq_drain
  import txq_pkg::*;
#(
  parameter int DEPTH = 1536,
  parameter int AW    = $clog2(DEPTH),
  parameter int FW_W  = $clog2(DEPTH + 1),
  parameter int CNT_W = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [31:0]     rd_data,
  input  logic            tx_ready,
  output logic [AW-1:0]   rd_addr,
  output logic [AW-1:0]   rd_next,
  output logic            tx_valid,
  output logic            tx_first,
  output logic            tx_last,
  output logic            frame_done,
  output logic [FW_W-1:0] done_words
);

  logic [CNT_W-1:0]    queued;
  logic                in_frame, accept;
  logic [TXQ_PW_W-1:0] rem;
  txq_hdr_t            hdr_view;

  assign hdr_view   = txq_hdr_t'(rd_data);
  assign tx_valid   = queued != '0;
  assign tx_first   = !in_frame;
  assign tx_last    = in_frame && (rem == TXQ_PW_W'(1));
  assign accept     = tx_valid && tx_ready;
  assign frame_done = accept && tx_last;
  assign rd_next    = AW'(fn_wrap_add(32'(rd_addr), 1, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr    <= '0;
      queued     <= '0;
      in_frame   <= 1'b0;
      rem        <= '0;
      done_words <= '0;
    end else begin
      case ({commit, frame_done})
        2'b10:   queued <= queued + CNT_W'(1);
        2'b01:   queued <= queued - CNT_W'(1);
        default: queued <= queued;
      endcase
      if (accept) begin
        rd_addr <= rd_next;
        if (!in_frame) begin
          in_frame   <= 1'b1;
          rem        <= fn_payload_words(hdr_view.bc);
          done_words <= FW_W'(fn_foot_words(hdr_view.bc));
        end else begin
          rem <= rem - TXQ_PW_W'(1);
          if (tx_last) in_frame <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/txq_mgr.sv
module txq_mgr
  import txq_pkg::*;
#(
  parameter int MEM_BYTES = 6144
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic        tx_first,
  output logic        tx_last
);

  localparam int DEPTH = MEM_BYTES / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW_W  = $clog2(DEPTH + 1);
  localparam int FB_W  = FW_W + 2;
  localparam int CNT_W = AW + 1;

  logic wr_ctrl, wr_sreq, wr_ien, wr_stat, wr_fhdr, wr_data;
  logic enq_wr, arm_set;
  logic auto_mode, autoinc, man_pend, man_set, man_clr;
  logic [AW-1:0] man_end;
  logic [15:0] sreq_q, ien_q, stat_q, stat_nx;

  logic hdr_accept, hdr_reject, commit, open, fits;
  logic [AW-1:0] frame_end, rd_addr, rd_next;
  logic [31:0] rd_data;
  logic frame_done, space_hit, armed;
  logic [FW_W-1:0] free_words, done_words, take_words;
  logic [FB_W-1:0] free_bytes;
  logic [TXQ_PW_W:0] fp_req;
  txq_hdr_t hdr_in;

  assign wr_ctrl = host_wr && (host_addr == REG_CTRL);
  assign wr_sreq = host_wr && (host_addr == REG_SREQ);
  assign wr_ien  = host_wr && (host_addr == REG_IEN);
  assign wr_stat = host_wr && (host_addr == REG_STAT);
  assign wr_fhdr = host_wr && (host_addr == REG_FHDR);
  assign wr_data = host_wr && (host_addr == REG_DATA);
  assign enq_wr  = wr_ctrl && host_wdata[0];
  assign arm_set = wr_ctrl && host_wdata[1];

  assign hdr_in     = txq_hdr_t'(host_wdata);
  assign fp_req     = fn_foot_words(hdr_in.bc);
  assign fits       = 32'(fp_req) <= 32'(free_words);
  assign take_words = FW_W'(fp_req);

  txq_space #(.DEPTH(DEPTH), .FW_W(FW_W), .FB_W(FB_W)) u_space (
    .clk(clk), .rst_n(rst_n),
    .take(hdr_accept), .take_words(take_words),
    .give(frame_done), .give_words(done_words),
    .arm_set(arm_set), .req_words(sreq_q),
    .free_words(free_words), .free_bytes(free_bytes),
    .armed(armed), .space_hit(space_hit)
  );

  txq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .hdr_wr(wr_fhdr), .hdr_in(hdr_in), .fits(fits),
    .data_wr(wr_data), .data_in(host_wdata),
    .autoinc(autoinc), .auto_mode(auto_mode), .enq_wr(enq_wr),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .hdr_accept(hdr_accept), .hdr_reject(hdr_reject),
    .commit(commit), .open(open), .frame_end(frame_end)
  );

  txq_drain #(.DEPTH(DEPTH), .AW(AW), .FW_W(FW_W), .CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .rd_data(rd_data), .tx_ready(tx_ready),
    .rd_addr(rd_addr), .rd_next(rd_next),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
    .frame_done(frame_done), .done_words(done_words)
  );

  assign tx_data = rd_data;

  // manual handshake: remembers where its frame ends in memory
  assign man_set = enq_wr && open;
  assign man_clr = man_pend && frame_done && (rd_next == man_end);

  always_comb begin
    stat_nx = stat_q;
    if (wr_stat) stat_nx = stat_nx & ~host_wdata[15:0];
    if (frame_done) stat_nx[ST_DONE]  = 1'b1;
    if (space_hit)  stat_nx[ST_SPACE] = 1'b1;
    if (hdr_reject) stat_nx[ST_ERR]   = 1'b1;
    stat_nx = stat_nx & STAT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_mode <= 1'b0;
      autoinc   <= 1'b0;
      man_pend  <= 1'b0;
      man_end   <= '0;
      sreq_q    <= '0;
      ien_q     <= '0;
      stat_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        auto_mode <= host_wdata[2];
        autoinc   <= host_wdata[3];
      end
      if (man_set) begin
        man_pend <= 1'b1;
        man_end  <= frame_end;
      end else if (man_clr) begin
        man_pend <= 1'b0;
      end
      if (wr_sreq) sreq_q <= host_wdata[15:0];
      if (wr_ien)  ien_q  <= host_wdata[15:0] & IEN_MASK;
      stat_q <= stat_nx;
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    case (host_addr)
      REG_CTRL: host_rdata = {28'd0, autoinc, auto_mode, armed, man_pend};
      REG_FREE: host_rdata = 32'(free_bytes);
      REG_SREQ: host_rdata = {16'd0, sreq_q};
      REG_IEN:  host_rdata = {16'd0, ien_q};
      REG_STAT: host_rdata = {16'd0, stat_q};
      default:  host_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/txq_mgr_chk.sv
module txq_mgr_chk #(
  parameter int MEM_BYTES = 6144,
  parameter int FB_W      = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [FB_W-1:0] free_bytes,
  input logic            hdr_accept,
  input logic            hdr_reject,
  input logic            frame_done,
  input logic            space_hit,
  input logic            armed,
  input logic            arm_set,
  input logic [15:0]     stat_q,
  input logic            man_pend,
  input logic            man_clr,
  input logic            tx_valid,
  input logic            tx_first,
  input logic [31:0]     tx_data
);

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_bytes) <= MEM_BYTES); // R3

  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_accept && !frame_done |=> free_bytes < $past(free_bytes)); // R3

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_reject && !frame_done |=> $stable(free_bytes)); // R2

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_reject |=> stat_q[0]); // R2

  AST_SPACE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    space_hit |=> stat_q[6]); // R7

  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !space_hit |=> armed); // R7

  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    space_hit && !arm_set |=> !armed); // R7

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> stat_q[14]); // R8

  AST_MAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    man_clr |=> !man_pend); // R5

  AST_HDR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_first |-> (tx_data[10:0] != 11'd0) && (tx_data[15:11] == 5'd0)); // R10

endmodule

bind txq_mgr txq_mgr_chk #(.MEM_BYTES(MEM_BYTES), .FB_W(FB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .free_bytes(free_bytes),
  .hdr_accept(hdr_accept), .hdr_reject(hdr_reject),
  .frame_done(frame_done), .space_hit(space_hit),
  .armed(armed), .arm_set(arm_set), .stat_q(stat_q),
  .man_pend(man_pend), .man_clr(man_clr),
  .tx_valid(tx_valid), .tx_first(tx_first), .tx_data(tx_data)
);

// File: tb/test_txq_mgr.sv
`timescale 1ns/1ps
module test_txq_mgr;

  localparam int MEM = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        irq, tx_valid, tx_first, tx_last;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;

  int n_chk = 0;
  int n_bad = 0;
  int exp_free = MEM;
  bit done_flag = 0;

  always #4 clk = ~clk;

  txq_mgr #(.MEM_BYTES(MEM)) i_txq_mgr (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last)
  );

  // bench's own footprint rule: header word plus payload rounded up to words
  function automatic int foot_bytes(input int bc);
    int words;
    words = bc / 4;
    if (bc % 4 != 0) words++;
    return 4 * (words + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic check_free(input string req);
    logic [31:0] v;
    rd(3'd1, v);
    check(req, v, 32'(exp_free));
  endtask

  function automatic logic [31:0] hdr(input logic [15:0] ctl, input int bc);
    return {ctl, 5'd0, 11'(bc)};
  endfunction

  task automatic drain(input string req, input logic [31:0] h, input int n, input logic [31:0] base);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      check({req, " valid"}, 32'(tx_valid), 32'd1);
      check({req, " data"}, tx_data, (i == 0) ? h : base + 32'(i - 1));
      check({req, " first"}, 32'(tx_first), 32'(i == 0));
      check({req, " last"}, 32'(tx_last), 32'(i == n));
      tx_ready = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic put_words(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) wr(3'd6, base + 32'(i));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    check_free("R1 free");
    rd(3'd4, v); check("R1 status", v, 32'd0);
    rd(3'd0, v); check("R1 control", v, 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 tx_valid", 32'(tx_valid), 32'd0);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    wr(3'd0, 32'hC);
    wr(3'd5, hdr(16'hABCD, 5)); exp_free -= foot_bytes(5);
    check_free("R3 take");
    check("R4 not yet queued", 32'(tx_valid), 32'd0);
    put_words(2, 32'hA000_0000);
    check("R4 queued", 32'(tx_valid), 32'd1);
    drain("R4", hdr(16'hABCD, 5), 2, 32'hA000_0000); exp_free += foot_bytes(5);
    check_free("R3 return");
    rd(3'd4, v); check("R8 done bit", v & 32'h4000, 32'h4000);
    check("R9 irq masked", 32'(irq), 32'd0);
    wr(3'd3, 32'h4000);
    check("R9 irq enabled", 32'(irq), 32'd1);
    wr(3'd4, 32'h4000);
    rd(3'd4, v); check("R9 w1c", v, 32'd0);
    check("R9 irq low", 32'(irq), 32'd0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_reserved();
    wr(3'd5, {16'h1234, 5'h1F, 11'd4}); exp_free -= foot_bytes(4);
    put_words(1, 32'h5150_0000);
    drain("R10", 32'h1234_0004, 1, 32'h5150_0000); exp_free += foot_bytes(4);
    wr(3'd4, 32'hFFFF);
  endtask

  task automatic t_reject();
    logic [31:0] v;
    wr(3'd5, hdr(16'h0, 0));
    rd(3'd4, v); check("R2 zero count flag", v, 32'd1);
    check_free("R2 zero count free");
    check("R2 zero count queue", 32'(tx_valid), 32'd0);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R9 err clear", v, 32'd0);
    wr(3'd5, hdr(16'h0, 100));
    rd(3'd4, v); check("R2 too big flag", v, 32'd1);
    check_free("R2 too big free");
    wr(3'd4, 32'h1);
  endtask

  task automatic t_ignored();
    wr(3'd6, 32'hDEAD_BEEF);
    check("R12 no queue", 32'(tx_valid), 32'd0);
    check_free("R12 free");
  endtask

  task automatic t_manual();
    logic [31:0] v;
    wr(3'd0, 32'h8);
    wr(3'd5, hdr(16'h5555, 8)); exp_free -= foot_bytes(8);
    put_words(2, 32'hB000_0000);
    check("R5 held back", 32'(tx_valid), 32'd0);
    rd(3'd0, v); check("R5 bit idle", v & 32'h1, 32'd0);
    wr(3'd0, 32'h9);
    rd(3'd0, v); check("R5 bit pending", v & 32'h1, 32'd1);
    check("R5 queued", 32'(tx_valid), 32'd1);
    drain("R5", hdr(16'h5555, 8), 2, 32'hB000_0000); exp_free += foot_bytes(8);
    rd(3'd0, v); check("R5 bit self-clear", v & 32'h1, 32'd0);
    check_free("R5 free");
    wr(3'd4, 32'hFFFF);
  endtask

  task automatic t_noinc();
    wr(3'd0, 32'h0);
    wr(3'd5, hdr(16'h0, 4)); exp_free -= foot_bytes(4);
    wr(3'd6, 32'h1111_1111);
    wr(3'd6, 32'h2222_2222);
    wr(3'd0, 32'h1);
    drain("R6", hdr(16'h0, 4), 1, 32'h2222_2222); exp_free += foot_bytes(4);
    wr(3'd4, 32'hFFFF);
  endtask

  task automatic t_space();
    logic [31:0] v;
    wr(3'd0, 32'hC);
    wr(3'd5, hdr(16'h7, 40)); exp_free -= foot_bytes(40);
    check_free("R3 large take");
    wr(3'd2, 32'd8);
    wr(3'd3, 32'h0040);
    wr(3'd0, 32'hE);
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); check("R7 not yet", v & 32'h40, 32'd0);
    rd(3'd0, v); check("R7 armed", v & 32'h2, 32'h2);
    wr(3'd5, hdr(16'h0, 4));
    rd(3'd4, v); check("R2 open frame flag", v & 32'h1, 32'h1);
    check_free("R2 open frame free");
    wr(3'd4, 32'h1);
    put_words(10, 32'hC000_0000);
    drain("R7 frame", hdr(16'h7, 40), 10, 32'hC000_0000); exp_free += foot_bytes(40);
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); check("R7 space bit", v & 32'h40, 32'h40);
    rd(3'd0, v); check("R7 disarmed", v & 32'h2, 32'd0);
    check("R9 space irq", 32'(irq), 32'd1);
    wr(3'd4, 32'hFFFF);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 4; r++) begin
      wr(3'd5, hdr(16'(r), 12)); exp_free -= foot_bytes(12);
      put_words(3, 32'hD000_0000 + 32'(r << 8));
      wr(3'd5, hdr(16'(r + 16), 20)); exp_free -= foot_bytes(20);
      put_words(5, 32'hE000_0000 + 32'(r << 8));
      check_free("R3 two frames");
      drain("R11 first", hdr(16'(r), 12), 3, 32'hD000_0000 + 32'(r << 8));
      exp_free += foot_bytes(12);
      drain("R11 second", hdr(16'(r + 16), 20), 5, 32'hE000_0000 + 32'(r << 8));
      exp_free += foot_bytes(20);
      check_free("R11 free");
    end
    wr(3'd4, 32'hFFFF);
  endtask

  task automatic t_full();
    logic [31:0] v;
    wr(3'd5, hdr(16'h9, 60)); exp_free -= foot_bytes(60);
    check("R3 full", 32'(exp_free), 32'd0);
    check_free("R3 full free");
    put_words(15, 32'hF000_0000);
    wr(3'd5, hdr(16'h0, 1));
    rd(3'd4, v); check("R2 full refuse", v & 32'h1, 32'h1);
    check_free("R2 full free");
    drain("R11 full frame", hdr(16'h9, 60), 15, 32'hF000_0000); exp_free += foot_bytes(60);
    check_free("R3 full return");
    rd(3'd4, v); check("R8 full done", v & 32'h4000, 32'h4000);
    check("R11 empty", 32'(tx_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_auto();
    t_reserved();
    t_reject();
    t_ignored();
    t_manual();
    t_noinc();
    t_space();
    t_wrap();
    t_full();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule